// File: doc/BRIEF.md
# SPI flash chip-erase command controller

This block is the slave-side command path of a serial flash. It takes 8-bit opcodes most significant bit first on the serial data input while chip select is low. The serial clock and pins are oversampled by a faster system clock. Data is sampled on rising serial-clock edges. Status bits are driven on falling edges. The block holds a write-enable latch, a busy (erase in progress) flag and three protect bits. The protect bits come from the `blk_prot` input.

A chip-erase command starts a self-timed cycle that fills a small internal byte array with ones. The cycle starts only if the write-enable latch is set, all protect bits are zero, and chip select rises right after the eighth opcode bit. The cycle length is a parameter counted in system clocks. The write-enable latch clears at the halfway point of the cycle.

A status read returns the status byte repeatedly for as long as chip select stays low, so software can poll the busy flag during an erase. While the cycle runs, every opcode other than status read is ignored. A side read port exposes the array contents.

Top module: `spi_erase_ctrl`

## Requirements
- R1: After reset the status byte reads 00h except bits 4:2, which follow `blk_prot`. `spi_miso` is 0 and every array byte reads 00h.
- R2: Opcode 06h sets the write-enable latch, which is status bit 1, once its eighth bit is sampled.
- R3: Opcode 05h returns the status byte MSB first. The first bit is driven on the falling edge that follows the eighth rising edge. The byte repeats while chip select is low. The layout is bit 0 busy, bit 1 write-enable latch, bits 4:2 `blk_prot`, bits 7:5 zero, and each byte is a snapshot taken at its first bit.
- R4: An accepted chip erase (opcode C7h) sets busy at the rising edge of chip select. Once it finishes, every array byte reads FFh.
- R5: Chip erase with the write-enable latch clear has no effect.
- R6: Chip erase is ignored when chip select rises after fewer or more than eight sampled bits.
- R7: Chip erase is ignored when any `blk_prot` bit is 1. Busy stays 0, the array is unchanged and the write-enable latch keeps its value.
- R8: Busy stays 1 for exactly ERASE_CYCLES system clocks and can be read through opcode 05h during that time.
- R9: The write-enable latch clears when half of ERASE_CYCLES has elapsed, while busy is still 1.
- R10: While busy is 1, every opcode except 05h is ignored. In particular, 06h does not set the latch again.
- R11: Unknown opcodes and incomplete opcodes leave the status unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, faster than the serial clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| spi_sclk | input | 1 | Serial clock |
| spi_cs_n | input | 1 | Active-low chip select |
| spi_mosi | input | 1 | Serial data input |
| spi_miso | output | 1 | Serial data output |
| blk_prot | input | 3 | Protect bits; any 1 blocks chip erase |
| mem_raddr | input | ADDR_W | Array read address |
| mem_rdata | output | 8 | Array byte at `mem_raddr` |

## Verification
A status read can overlap the running erase timer. In that case busy and the write-enable latch can change while the status byte is being shifted out. The bench provokes this by issuing reads right after the erase starts, just past the halfway point, and after the end. It checks each byte against the state the requirements predict for that instant. A write-enable command sent after the halfway point of an active erase is judged through a later status read: the latch must still read 0.

// File: rtl/spi_erase_pkg.sv
package spi_erase_pkg;

    localparam logic [7:0] OP_WR_ENABLE  = 8'h06;
    localparam logic [7:0] OP_RD_STATUS  = 8'h05;
    localparam logic [7:0] OP_CHIP_ERASE = 8'hC7;

    localparam logic [3:0] FULL_OPCODE_BITS = 4'd8;

    function automatic logic [7:0] pack_status(input logic busy,
                                               input logic wel,
                                               input logic [2:0] prot);
        return {3'b000, prot, wel, busy};
    endfunction

endpackage

// File: rtl/spi_pin_sync.sv
module spi_pin_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sclk,
    input  logic cs_n,
    input  logic mosi,
    output logic sclk_rise,
    output logic sclk_fall,
    output logic cs_rise,
    output logic cs_fall,
    output logic cs_low,
    output logic mosi_s
);
    localparam int NCH = 3;
    localparam int PW  = STAGES + 1;
    // idle pin levels, channel order {mosi, cs_n, sclk}
    localparam logic [NCH-1:0] IDLE = 3'b010;

    typedef struct packed {
        logic [NCH-1:0][PW-1:0] pipe;
    } sync_t;

    sync_t sync_d, sync_q;
    logic [NCH-1:0] raw, cur, prev;

    assign raw = {mosi, cs_n, sclk};

    always_comb begin
        sync_d = sync_q;
        for (int ch = 0; ch < NCH; ch++) begin
            sync_d.pipe[ch] = {sync_q.pipe[ch][PW-2:0], raw[ch]};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int ch = 0; ch < NCH; ch++) begin
                sync_q.pipe[ch] <= {PW{IDLE[ch]}};
            end
        end else begin
            sync_q <= sync_d;
        end
    end

    for (genvar ch = 0; ch < NCH; ch++) begin : g_tap
        assign cur[ch]  = sync_q.pipe[ch][STAGES-1];
        assign prev[ch] = sync_q.pipe[ch][STAGES];
    end

    assign sclk_rise = cur[0] & ~prev[0];
    assign sclk_fall = ~cur[0] & prev[0];
    assign cs_rise   = cur[1] & ~prev[1];
    assign cs_fall   = ~cur[1] & prev[1];
    assign cs_low    = ~cur[1];
    assign mosi_s    = cur[2];

endmodule

// File: rtl/spi_cmd_shifter.sv
module spi_cmd_shifter
    import spi_erase_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sclk_rise,
    input  logic       sclk_fall,
    input  logic       cs_fall,
    input  logic       cs_low,
    input  logic       mosi_s,
    input  logic [7:0] status,
    output logic [7:0] opcode,
    output logic       op_strobe,
    output logic [3:0] bit_cnt,
    output logic       miso
);
    typedef struct packed {
        logic [7:0] shreg;
        logic [3:0] cnt;
        logic       strobe;
        logic       rd_act;
        logic [2:0] ocnt;
        logic [7:0] snap;
        logic       miso;
    } shf_t;

    shf_t shf_d, shf_q;
    logic [7:0] next_shreg;

    assign next_shreg = {shf_q.shreg[6:0], mosi_s};

    always_comb begin
        shf_d        = shf_q;
        shf_d.strobe = 1'b0;
        if (cs_fall) begin
            shf_d.cnt    = '0;
            shf_d.rd_act = 1'b0;
            shf_d.ocnt   = '0;
            shf_d.miso   = 1'b0;
        end else if (cs_low) begin
            if (sclk_rise) begin
                shf_d.shreg = next_shreg;
                shf_d.cnt   = (shf_q.cnt == 4'hF) ? 4'hF : shf_q.cnt + 4'd1;
                if (shf_q.cnt == FULL_OPCODE_BITS - 4'd1) begin
                    shf_d.strobe = 1'b1;
                    shf_d.ocnt   = '0;
                    shf_d.rd_act = (next_shreg == OP_RD_STATUS);
                end
            end
            if (sclk_fall && shf_q.rd_act) begin
                if (shf_q.ocnt == 3'd0) begin
                    shf_d.snap = status;
                    shf_d.miso = status[7];
                end else begin
                    shf_d.miso = shf_q.snap[3'd7 - shf_q.ocnt];
                end
                shf_d.ocnt = shf_q.ocnt + 3'd1;
            end
        end else begin
            shf_d.rd_act = 1'b0;
            shf_d.miso   = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) shf_q <= '0;
        else        shf_q <= shf_d;
    end

    assign opcode    = shf_q.shreg;
    assign op_strobe = shf_q.strobe;
    assign bit_cnt   = shf_q.cnt;
    assign miso      = shf_q.miso;

    AST_MISO_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_low && !$past(cs_low)) |-> !shf_q.miso);   // R3
    AST_STROBE_AT_EIGHT: assert property (@(posedge clk) disable iff (!rst_n)
        shf_q.strobe |-> shf_q.cnt == FULL_OPCODE_BITS); // R2

endmodule

// File: rtl/erase_engine.sv
module erase_engine #(
    parameter int MEM_DEPTH    = 16,
    parameter int ERASE_CYCLES = 64,
    parameter int ADDR_W       = $clog2(MEM_DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [ADDR_W-1:0] raddr,
    output logic              busy,
    output logic              wel_clear,
    output logic [7:0]        rdata
);
    localparam int EW = $clog2(ERASE_CYCLES + 1);
    localparam logic [EW-1:0] LAST     = EW'(ERASE_CYCLES - 1);
    localparam logic [EW-1:0] HALF_M1  = EW'(ERASE_CYCLES / 2 - 1);
    localparam logic [EW-1:0] FILL_END = EW'(MEM_DEPTH);

    typedef struct packed {
        logic                        busy;
        logic                        wel_clear;
        logic [EW-1:0]               elapsed;
        logic [MEM_DEPTH-1:0][7:0]   mem;
    } eng_t;

    eng_t eng_d, eng_q;

    always_comb begin
        eng_d           = eng_q;
        eng_d.wel_clear = eng_q.busy && (eng_q.elapsed == HALF_M1);
        if (!eng_q.busy) begin
            if (start) begin
                eng_d.busy    = 1'b1;
                eng_d.elapsed = '0;
            end
        end else begin
            if (eng_q.elapsed < FILL_END) begin
                eng_d.mem[eng_q.elapsed[ADDR_W-1:0]] = 8'hFF;
            end
            if (eng_q.elapsed == LAST) begin
                eng_d.busy    = 1'b0;
                eng_d.elapsed = '0;
            end else begin
                eng_d.elapsed = eng_q.elapsed + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) eng_q <= '0;
        else        eng_q <= eng_d;
    end

    assign busy      = eng_q.busy;
    assign wel_clear = eng_q.wel_clear;
    assign rdata     = eng_q.mem[raddr];

    AST_BUSY_LENGTH: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(eng_q.busy) |-> $past(eng_q.elapsed) == LAST);   // R8
    AST_CLEAR_INSIDE: assert property (@(posedge clk) disable iff (!rst_n)
        eng_q.wel_clear |-> eng_q.busy);                       // R9
    AST_FILL_ONLY_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(eng_q.mem) |-> $past(eng_q.busy));            // R7

endmodule

// File: rtl/spi_erase_ctrl.sv
module spi_erase_ctrl
    import spi_erase_pkg::*;
#(
    parameter int MEM_DEPTH    = 16,
    parameter int ERASE_CYCLES = 64,
    parameter int SYNC_STAGES  = 2,
    parameter int ADDR_W       = $clog2(MEM_DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              spi_sclk,
    input  logic              spi_cs_n,
    input  logic              spi_mosi,
    output logic              spi_miso,
    input  logic [2:0]        blk_prot,
    input  logic [ADDR_W-1:0] mem_raddr,
    output logic [7:0]        mem_rdata
);
    typedef struct packed {
        logic wel;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic       sclk_rise, sclk_fall, cs_rise, cs_fall, cs_low, mosi_s;
    logic [7:0] opcode, status;
    logic       op_strobe, busy, wel_clear, start;
    logic [3:0] bit_cnt;

    spi_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n),
        .sclk(spi_sclk), .cs_n(spi_cs_n), .mosi(spi_mosi),
        .sclk_rise(sclk_rise), .sclk_fall(sclk_fall),
        .cs_rise(cs_rise), .cs_fall(cs_fall),
        .cs_low(cs_low), .mosi_s(mosi_s)
    );

    assign status = pack_status(busy, ctl_q.wel, blk_prot);

    spi_cmd_shifter u_shift (
        .clk(clk), .rst_n(rst_n),
        .sclk_rise(sclk_rise), .sclk_fall(sclk_fall),
        .cs_fall(cs_fall), .cs_low(cs_low), .mosi_s(mosi_s),
        .status(status), .opcode(opcode), .op_strobe(op_strobe),
        .bit_cnt(bit_cnt), .miso(spi_miso)
    );

    assign start = cs_rise && (bit_cnt == FULL_OPCODE_BITS)
                && (opcode == OP_CHIP_ERASE) && !busy
                && ctl_q.wel && (blk_prot == 3'b000);

    erase_engine #(
        .MEM_DEPTH(MEM_DEPTH), .ERASE_CYCLES(ERASE_CYCLES), .ADDR_W(ADDR_W)
    ) u_engine (
        .clk(clk), .rst_n(rst_n), .start(start), .raddr(mem_raddr),
        .busy(busy), .wel_clear(wel_clear), .rdata(mem_rdata)
    );

    always_comb begin
        ctl_d = ctl_q;
        if (wel_clear) begin
            ctl_d.wel = 1'b0;
        end else if (op_strobe && !busy && opcode == OP_WR_ENABLE) begin
            ctl_d.wel = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    AST_ERASE_NEEDS_WEL: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(ctl_q.wel));                 // R5
    AST_ERASE_NEEDS_UNPROT: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(blk_prot) == 3'b000);        // R7
    AST_ERASE_EXACT_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(bit_cnt) == FULL_OPCODE_BITS); // R6
    AST_WEL_GONE_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> !ctl_q.wel);                       // R9
    AST_NO_WEL_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ctl_q.wel) |-> !$past(busy));                // R10

    initial begin
        if (ERASE_CYCLES < MEM_DEPTH || ERASE_CYCLES < 4)
            $error("ERASE_CYCLES too small for MEM_DEPTH");
    end

endmodule

// File: tb/spi_erase_ctrl_tb_top.sv
module spi_erase_ctrl_tb_top;
    localparam int DEPTH = 16;
    localparam int ECYC  = 3000;
    localparam int AW    = $clog2(DEPTH);
    localparam int H     = 6;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          spi_sclk = 1'b0;
    logic          spi_cs_n = 1'b1;
    logic          spi_mosi = 1'b0;
    logic          spi_miso;
    logic [2:0]    blk_prot = 3'b000;
    logic [AW-1:0] mem_raddr = '0;
    logic [7:0]    mem_rdata;

    int n_checks = 0;
    int n_fail   = 0;
    int unsigned cyc = 0;
    bit done = 1'b0;
    logic exp_wel = 1'b0;

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    spi_erase_ctrl #(.MEM_DEPTH(DEPTH), .ERASE_CYCLES(ECYC)) dut_i (
        .clk(clk), .rst_n(rst_n), .spi_sclk(spi_sclk), .spi_cs_n(spi_cs_n),
        .spi_mosi(spi_mosi), .spi_miso(spi_miso), .blk_prot(blk_prot),
        .mem_raddr(mem_raddr), .mem_rdata(mem_rdata)
    );

    function automatic logic [7:0] exp_status(input logic busy, input logic wel,
                                              input logic [2:0] prot);
        return {3'b000, prot, wel, busy};
    endfunction

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic cs_open();
        spi_cs_n = 1'b0;
        wait_clk(H);
    endtask

    task automatic clock_bit(input logic b, output logic so);
        spi_sclk = 1'b0;
        spi_mosi = b;
        wait_clk(H);
        so = spi_miso;
        spi_sclk = 1'b1;
        wait_clk(H);
    endtask

    task automatic cs_close();
        spi_sclk = 1'b0;
        wait_clk(H);
        spi_cs_n = 1'b1;
        wait_clk(2 * H);
    endtask

    task automatic send_cmd(input logic [7:0] op, input int nbits);
        logic so;
        cs_open();
        for (int i = 0; i < nbits; i++) begin
            clock_bit((i < 8) ? op[7 - i] : 1'($urandom_range(1, 0)), so);
        end
        cs_close();
    endtask

    task automatic read_status(output logic [7:0] b0, output logic [7:0] b1);
        logic so;
        cs_open();
        for (int i = 0; i < 8; i++) clock_bit(8'h05 >> (7 - i), so);
        for (int i = 0; i < 16; i++) begin
            clock_bit(1'b0, so);
            if (i < 8) b0[7 - i] = so;
            else       b1[15 - i] = so;
        end
        cs_close();
    endtask

    task automatic check_mem(input string req, input logic [7:0] exp);
        for (int a = 0; a < DEPTH; a++) begin
            mem_raddr = AW'(a);
            wait_clk(1);
            check(req, $sformatf("array byte %0d", a), {24'h0, mem_rdata}, {24'h0, exp});
        end
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin : main
        logic [7:0] s0, s1, op;
        logic [2:0] p;
        int unsigned t0, seed;
        seed = $urandom(32'd2024);
        wait_clk(4);
        rst_n = 1'b1;
        wait_clk(4);

        // R1 reset state
        check("R1", "idle miso", {31'h0, spi_miso}, 32'h0);
        read_status(s0, s1);
        check("R1", "status after reset", {24'h0, s0}, {24'h0, exp_status(0, 0, 3'b000)});
        check_mem("R1", 8'h00);

        // R5 erase without write enable
        send_cmd(8'hC7, 8);
        read_status(s0, s1);
        check("R5", "erase without latch", {24'h0, s0}, {24'h0, exp_status(0, 0, 3'b000)});

        // R2 write enable
        send_cmd(8'h06, 8);
        exp_wel = 1'b1;
        read_status(s0, s1);
        check("R2", "latch after 06h", {24'h0, s0}, {24'h0, exp_status(0, 1, 3'b000)});
        check("R3", "status repeats", {24'h0, s1}, {24'h0, s0});
        blk_prot = 3'b101;
        read_status(s0, s1);
        check("R3", "status layout 16h", {24'h0, s0}, 32'h16);

        // R7 protected erase with random nonzero protect patterns
        for (int k = 0; k < 4; k++) begin
            p = 3'($urandom_range(7, 1));
            blk_prot = p;
            send_cmd(8'hC7, 8);
            wait_clk(20);
            read_status(s0, s1);
            check("R7", "protected erase ignored", {24'h0, s0}, {24'h0, exp_status(0, 1, p)});
        end
        blk_prot = 3'b000;

        // R6 wrong bit counts
        send_cmd(8'hC7, 7);
        read_status(s0, s1);
        check("R6", "cs after 7 bits", {24'h0, s0}, {24'h0, exp_status(0, 1, 3'b000)});
        send_cmd(8'hC7, 9);
        read_status(s0, s1);
        check("R6", "cs after 9 bits", {24'h0, s0}, {24'h0, exp_status(0, 1, 3'b000)});

        // R11 random unknown and partial opcodes
        for (int k = 0; k < 8; k++) begin
            int nb;
            do op = 8'($urandom); while (op == 8'h06 || op == 8'h05 || op == 8'hC7);
            nb = $urandom_range(12, 1);
            send_cmd(op, nb);
            read_status(s0, s1);
            check("R11", $sformatf("op %0h bits %0d", op, nb), {24'h0, s0},
                  {24'h0, exp_status(0, 1, 3'b000)});
        end
        check_mem("R7", 8'h00);

        // R4 R8 R9 R10 accepted erase with overlapping status reads
        send_cmd(8'hC7, 8);
        t0 = cyc;
        read_status(s0, s1);
        check("R8", "busy early", {24'h0, s0}, {24'h0, exp_status(1, 1, 3'b000)});
        while (cyc < t0 + 1600) wait_clk(1);
        read_status(s0, s1);
        check("R9", "latch cleared past half", {24'h0, s0}, {24'h0, exp_status(1, 0, 3'b000)});
        send_cmd(8'h06, 8);
        read_status(s0, s1);
        check("R10", "06h ignored while busy", {24'h0, s0}, {24'h0, exp_status(1, 0, 3'b000)});
        while (cyc < t0 + ECYC + 100) wait_clk(1);
        read_status(s0, s1);
        check("R8", "busy ended", {24'h0, s0}, {24'h0, exp_status(0, 0, 3'b000)});
        check_mem("R4", 8'hFF);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule